// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Bus Port

This block is the host-facing port of a display controller. A host processor reaches it over a parallel bus that uses one of two timing styles. In the first, the host uses separate active-low read and write strobes. In the second, the host uses an enable strobe together with a read/write direction level. Three static mode pins choose the style and a bus width of 8, 16 or 18 bits. Every input from the host, including the data lines, passes through a two-flop synchroniser into the core clock. The port then finds the trailing edge of each strobe and turns every transfer into one single-cycle internal pulse.

Each transfer is sorted by A0 and by direction into four kinds: display-data write, instruction write, display-data read or status read. A write yields `wr_pulse` along with the captured, width-masked data and a flag that is high for display data. A read drives the active bus lanes from `disp_rdata` (when A0 is high) or from `stat_rdata` (when A0 is low) while the read strobe is active. When the read ends, the port gives `rd_pulse` so the core can advance its read pointer. The port drives the pad ring through a per-lane output enable. It never drives lanes above the chosen width. Mode codes that name no configuration shut the port down.

Top module: `pbus_host_port`

## Requirements
- R1: After reset, `wr_pulse` and `rd_pulse` are low, `wr_data`, `bus_out` and `bus_oe` are all zero.
- R2: `mode_sel[2]` = 0 selects separate-strobe timing and 1 selects enable-plus-direction timing. `mode_sel[1:0]` = 00, 01, 10 select 8, 16, 18 bit width. Code 11 (with either value of bit 2) is invalid: no pulse is produced and `bus_oe` stays zero whatever the strobes do.
- R3: While `host_cs_n` is high, no strobe activity produces a pulse or enables any lane.
- R4: Separate-strobe write. `host_cs_n` is low and `hst_rd_en` is high. A rising edge of `hst_wr_dir` gives `wr_pulse` high for one cycle. The pulse appears at the third clock edge after the edge. `wr_data` holds `bus_in` as it was at that edge.
- R5: Separate-strobe read. `host_cs_n` is low and `hst_wr_dir` is high. While `hst_rd_en` is low, `bus_oe` enables the active lanes from the third clock edge after the falling edge. A rising edge of `hst_rd_en` gives a one-cycle `rd_pulse` three edges later. At that point `bus_oe` is zero.
- R6: Enable-plus-direction write. `host_cs_n` is low and `hst_wr_dir` is low (write). A falling edge of `hst_rd_en` (enable) gives a one-cycle `wr_pulse` three edges later, with `bus_in` captured.
- R7: Enable-plus-direction read. `host_cs_n` is low and `hst_wr_dir` is high (read). While `hst_rd_en` is high, the active lanes are driven from the third edge on. The falling edge of the enable gives a one-cycle `rd_pulse` three edges later, with `bus_oe` zero.
- R8: `wr_is_data` and `rd_is_data` equal the A0 level of the transfer. A read drives `disp_rdata` when A0 is high and `stat_rdata` when A0 is low.
- R9: Lanes at or above the selected width are zero in `wr_data`, `bus_out` and `bus_oe`.
- R10: Each transfer gives exactly one pulse. A read pulse and a write pulse never occur together. A strobe edge counts only if chip select was already low in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Static bus style and width select |
| host_cs_n | input | 1 | Active-low chip select |
| host_a0 | input | 1 | High: display data, low: instruction/status |
| hst_rd_en | input | 1 | Read strobe (active low) or enable (active high) |
| hst_wr_dir | input | 1 | Write strobe (active low) or direction (high = read) |
| bus_in | input | 18 | Data bus as seen at the pads |
| bus_out | output | 18 | Read data toward the pads |
| bus_oe | output | 18 | Per-lane pad output enable |
| disp_rdata | input | 18 | Display data offered by the core for reads |
| stat_rdata | input | 18 | Status word offered by the core for reads |
| wr_pulse | output | 1 | One-cycle write event |
| wr_data | output | 18 | Captured write data, width-masked |
| wr_is_data | output | 1 | Write carries display data (A0 high) |
| rd_pulse | output | 1 | One-cycle read-complete event |
| rd_is_data | output | 1 | Completed read was display data |

## Verification
Every result shows up three clock edges after the pin change that causes it: two synchroniser flops, then the registered output stage. The bench drives each pin change just after a falling clock edge. It then watches six successive falling edges and records on which one a pulse is seen. A pulse counts as correct only if exactly one is seen, and it falls on the third falling edge. Lane enables are checked as still off on the second falling edge after the strobe activates and as on at the third. In the invalid-mode and chip-select-high cases, the same windows must stay empty.

// File: rtl/pbus_pkg.sv
`timescale 1ns/1ps
package pbus_pkg;

  typedef struct packed {
    logic       ok;     // code names a real configuration
    logic       m68;    // enable plus direction timing
    logic [1:0] wsel;   // 0: narrow, 1: mid, 2: full width
  } pbus_mode_t;

  function automatic pbus_mode_t decode_mode(input logic [2:0] code);
    pbus_mode_t m;
    m.m68  = code[2];
    m.wsel = code[1:0];
    m.ok   = (code[1:0] != 2'b11);
    return m;
  endfunction

endpackage

// File: rtl/pbus_sync.sv
`timescale 1ns/1ps
module pbus_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= RST_VAL;
    else        st[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[g] <= RST_VAL;
      else        st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pbus_classify.sv
`timescale 1ns/1ps
module pbus_classify
  import pbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pbus_mode_t mode,
  input  logic       cs_n_s,
  input  logic       rd_en_s,
  input  logic       wr_dir_s,
  output logic       wr_evt,
  output logic       rd_evt,
  output logic       rd_live
);
  logic rd_en_q, wr_dir_q, cs_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q  <= 1'b1;
      wr_dir_q <= 1'b1;
      cs_n_q   <= 1'b1;
    end else begin
      rd_en_q  <= rd_en_s;
      wr_dir_q <= wr_dir_s;
      cs_n_q   <= cs_n_s;
    end
  end

  // named edge and qualifier wires
  logic rd_en_rise, rd_en_fall, wr_dir_rise;
  logic sel_now, sel_held;
  assign rd_en_rise  = rd_en_s & ~rd_en_q;
  assign rd_en_fall  = ~rd_en_s & rd_en_q;
  assign wr_dir_rise = wr_dir_s & ~wr_dir_q;
  assign sel_now     = mode.ok & ~cs_n_s;
  assign sel_held    = sel_now & ~cs_n_q;

  logic wr_raw, rd_raw, live_raw;
  always_comb begin
    if (mode.m68) begin
      wr_raw   = rd_en_fall & ~wr_dir_s;
      rd_raw   = rd_en_fall &  wr_dir_s;
      live_raw = rd_en_s    &  wr_dir_s;
    end else begin
      wr_raw   = wr_dir_rise & rd_en_s;
      rd_raw   = rd_en_rise  & wr_dir_s;
      live_raw = ~rd_en_s    & wr_dir_s;
    end
  end

  assign wr_evt  = wr_raw   & sel_held;
  assign rd_evt  = rd_raw   & sel_held;
  assign rd_live = live_raw & sel_now;

  // R10
  no_dual_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_evt && rd_evt));
  // R10
  wr_evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
endmodule

// File: rtl/pbus_capture.sv
`timescale 1ns/1ps
module pbus_capture
  import pbus_pkg::*;
#(
  parameter int BUS_W    = 18,
  parameter int NARROW_W = 8,
  parameter int MID_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pbus_mode_t       mode,
  input  logic             wr_evt,
  input  logic             rd_evt,
  input  logic             rd_live,
  input  logic             a0_s,
  input  logic [BUS_W-1:0] din_s,
  input  logic [BUS_W-1:0] disp_rdata,
  input  logic [BUS_W-1:0] stat_rdata,
  output logic             wr_pulse,
  output logic [BUS_W-1:0] wr_data,
  output logic             wr_is_data,
  output logic             rd_pulse,
  output logic             rd_is_data,
  output logic [BUS_W-1:0] bus_out,
  output logic [BUS_W-1:0] bus_oe
);
  function automatic logic [BUS_W-1:0] lane_mask(input logic [1:0] wsel);
    logic [BUS_W-1:0] m;
    int w;
    case (wsel)
      2'd0:    w = NARROW_W;
      2'd1:    w = MID_W;
      default: w = BUS_W;
    endcase
    for (int i = 0; i < BUS_W; i++) m[i] = (i < w);
    return m;
  endfunction

  logic [BUS_W-1:0] lanes, rd_src;
  assign lanes  = lane_mask(mode.wsel);
  assign rd_src = a0_s ? disp_rdata : stat_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pulse   <= 1'b0;
      wr_data    <= '0;
      wr_is_data <= 1'b0;
      rd_pulse   <= 1'b0;
      rd_is_data <= 1'b0;
      bus_out    <= '0;
      bus_oe     <= '0;
    end else begin
      wr_pulse <= wr_evt;
      rd_pulse <= rd_evt;
      if (wr_evt) begin
        wr_data    <= din_s & lanes;
        wr_is_data <= a0_s;
      end
      if (rd_evt) rd_is_data <= a0_s;
      bus_oe  <= rd_live ? lanes : '0;
      bus_out <= rd_live ? (rd_src & lanes) : '0;
    end
  end

  // R10
  wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
  // R10
  rd_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |=> !rd_pulse);
  // R10
  no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_pulse && rd_pulse));
  // R9
  oe_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe & ~lanes) == '0);
  // R9
  wr_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> (wr_data & ~lanes) == '0);
  // R2
  oe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe != '0) |-> $past(mode.ok));
  // R5
  rd_end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |-> bus_oe == '0);
endmodule

// File: rtl/pbus_host_port.sv
`timescale 1ns/1ps
module pbus_host_port
  import pbus_pkg::*;
#(
  parameter int BUS_W    = 18,
  parameter int NARROW_W = 8,
  parameter int MID_W    = 16,
  parameter int SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_sel,
  input  logic             host_cs_n,
  input  logic             host_a0,
  input  logic             hst_rd_en,
  input  logic             hst_wr_dir,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] bus_out,
  output logic [BUS_W-1:0] bus_oe,
  input  logic [BUS_W-1:0] disp_rdata,
  input  logic [BUS_W-1:0] stat_rdata,
  output logic             wr_pulse,
  output logic [BUS_W-1:0] wr_data,
  output logic             wr_is_data,
  output logic             rd_pulse,
  output logic             rd_is_data
);
  localparam int CTL_W = 4;

  pbus_mode_t mode;
  assign mode = decode_mode(mode_sel);

  logic [CTL_W-1:0] ctl_s;
  logic [BUS_W-1:0] din_s;
  logic cs_n_s, a0_s, rd_en_s, wr_dir_s;

  pbus_sync #(.W(CTL_W), .STAGES(SYNC_N), .RST_VAL(4'b1011)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({host_cs_n, host_a0, hst_rd_en, hst_wr_dir}),
    .q(ctl_s)
  );
  assign {cs_n_s, a0_s, rd_en_s, wr_dir_s} = ctl_s;

  pbus_sync #(.W(BUS_W), .STAGES(SYNC_N), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(din_s)
  );

  logic wr_evt, rd_evt, rd_live;

  pbus_classify u_cls (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .cs_n_s(cs_n_s), .rd_en_s(rd_en_s), .wr_dir_s(wr_dir_s),
    .wr_evt(wr_evt), .rd_evt(rd_evt), .rd_live(rd_live)
  );

  pbus_capture #(.BUS_W(BUS_W), .NARROW_W(NARROW_W), .MID_W(MID_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .wr_evt(wr_evt), .rd_evt(rd_evt), .rd_live(rd_live),
    .a0_s(a0_s), .din_s(din_s),
    .disp_rdata(disp_rdata), .stat_rdata(stat_rdata),
    .wr_pulse(wr_pulse), .wr_data(wr_data), .wr_is_data(wr_is_data),
    .rd_pulse(rd_pulse), .rd_is_data(rd_is_data),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  // R3
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(host_cs_n, 3) && $past(host_cs_n, 4)) |-> !wr_pulse && !rd_pulse);
endmodule

// File: tb/test_pbus_host_port.sv
`timescale 1ns/1ps
module test_pbus_host_port;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_sel = 3'b000;
  logic host_cs_n = 1'b1, host_a0 = 1'b0, hst_rd_en = 1'b1, hst_wr_dir = 1'b1;
  logic [W-1:0] bus_in = '0, disp_rdata = '0, stat_rdata = '0;
  logic [W-1:0] bus_out, bus_oe, wr_data;
  logic wr_pulse, wr_is_data, rd_pulse, rd_is_data;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pbus_host_port i_pbus_host_port (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .host_cs_n(host_cs_n),
    .host_a0(host_a0), .hst_rd_en(hst_rd_en), .hst_wr_dir(hst_wr_dir),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .disp_rdata(disp_rdata), .stat_rdata(stat_rdata),
    .wr_pulse(wr_pulse), .wr_data(wr_data), .wr_is_data(wr_is_data),
    .rd_pulse(rd_pulse), .rd_is_data(rd_is_data)
  );

  function automatic logic [W-1:0] exp_lanes(input logic [2:0] m);
    case (m[1:0])
      2'b00:   return W'(18'h000FF);
      2'b01:   return W'(18'h0FFFF);
      2'b10:   return W'(18'h3FFFF);
      default: return '0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    host_cs_n  = 1'b1;
    hst_rd_en  = mode_sel[2] ? 1'b0 : 1'b1;
    hst_wr_dir = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    host_cs_n = 1'b1;
    mode_sel  = m;
    go_idle();
  endtask

  // watch six falling edges, expect a lone pulse on the third when live
  task automatic watch(input bit want_wr, input bit live, input string req,
                       output logic [W-1:0] dat, output logic flag);
    int hits = 0, at = 0;
    dat = '0; flag = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (want_wr ? wr_pulse : rd_pulse) begin
        hits++; at = i;
        dat  = want_wr ? wr_data : bus_oe;
        flag = want_wr ? wr_is_data : rd_is_data;
      end
      if (!want_wr && rd_pulse == 1'b0 && wr_pulse) hits = hits + 10;
      if (want_wr && rd_pulse) hits = hits + 10;
    end
    if (live) chk(hits == 1 && at == 3, req, "pulse count/slot", hits * 16 + at, 32'h13);
    else      chk(hits == 0, req, "pulse when shut", hits, 0);
  endtask

  task automatic do_write(input logic a0, input logic [W-1:0] d, input bit cs_on);
    bit live = cs_on && (mode_sel[1:0] != 2'b11);
    string req = !cs_on ? "R3" : (mode_sel[1:0] == 2'b11) ? "R2" : mode_sel[2] ? "R6" : "R4";
    logic [W-1:0] got; logic fl;
    @(negedge clk);
    host_cs_n = !cs_on; host_a0 = a0; bus_in = d;
    if (mode_sel[2]) hst_wr_dir = 1'b0;
    repeat (2) @(negedge clk);
    if (mode_sel[2]) hst_rd_en = 1'b1; else hst_wr_dir = 1'b0;
    repeat (3) @(negedge clk);
    if (mode_sel[2]) hst_rd_en = 1'b0; else hst_wr_dir = 1'b1;
    watch(1'b1, live, req, got, fl);
    if (live) begin
      chk(got == (d & exp_lanes(mode_sel)), "R9", "write data lanes", got, d & exp_lanes(mode_sel));
      chk(fl == a0, "R8", "write A0 flag", fl, a0);
    end
    go_idle();
  endtask

  task automatic do_read(input logic a0, input logic [W-1:0] dv, input logic [W-1:0] sv,
                         input bit cs_on);
    bit live = cs_on && (mode_sel[1:0] != 2'b11);
    string req = !cs_on ? "R3" : (mode_sel[1:0] == 2'b11) ? "R2" : mode_sel[2] ? "R7" : "R5";
    logic [W-1:0] lanes = live ? exp_lanes(mode_sel) : '0;
    logic [W-1:0] src = a0 ? dv : sv;
    logic [W-1:0] got; logic fl;
    @(negedge clk);
    host_cs_n = !cs_on; host_a0 = a0; disp_rdata = dv; stat_rdata = sv;
    if (mode_sel[2]) hst_wr_dir = 1'b1;
    repeat (2) @(negedge clk);
    hst_rd_en = mode_sel[2] ? 1'b1 : 1'b0;
    repeat (2) @(negedge clk);
    chk(bus_oe == '0, req, "oe early", bus_oe, 0);
    @(negedge clk);
    chk(bus_oe == lanes, req, "oe during read", bus_oe, lanes);
    chk(bus_out == (src & lanes), "R8", "read data source/lanes", bus_out, src & lanes);
    @(negedge clk);
    hst_rd_en = mode_sel[2] ? 1'b0 : 1'b1;
    watch(1'b0, live, req, got, fl);
    chk(bus_oe == '0, req, "oe released", bus_oe, 0);
    if (live) chk(fl == a0, "R8", "read A0 flag", fl, a0);
    go_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(wr_pulse == 0 && rd_pulse == 0, "R1", "pulses in reset", {wr_pulse, rd_pulse}, 0);
    chk(wr_data == '0, "R1", "wr_data in reset", wr_data, 0);
    chk(bus_oe == '0 && bus_out == '0, "R1", "bus in reset", bus_oe, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(wr_pulse == 0 && rd_pulse == 0 && bus_oe == '0, "R1", "after reset", bus_oe, 0);

    // directed: every valid mode, both directions, both A0 levels
    for (int m = 0; m < 8; m++) begin
      if (m[1:0] == 2'b11) continue;
      set_mode(3'(m));
      do_write(1'b1, 18'h3A5C3, 1'b1);
      do_write(1'b0, 18'h2FF0F, 1'b1);
      do_read(1'b1, 18'h3C3A5, 18'h15A5A, 1'b1);
      do_read(1'b0, 18'h3C3A5, 18'h15A5A, 1'b1);
    end
    // R2 invalid codes
    set_mode(3'b011);
    do_write(1'b1, 18'h3FFFF, 1'b1);
    do_read(1'b1, 18'h3FFFF, 18'h3FFFF, 1'b1);
    set_mode(3'b111);
    do_write(1'b0, 18'h12345, 1'b1);
    do_read(1'b0, 18'h3FFFF, 18'h3FFFF, 1'b1);
    // R3 chip select high
    set_mode(3'b010);
    do_write(1'b1, 18'h3FFFF, 1'b0);
    do_read(1'b1, 18'h3FFFF, 18'h3FFFF, 1'b0);
    set_mode(3'b110);
    do_write(1'b1, 18'h3FFFF, 1'b0);
    do_read(1'b0, 18'h3FFFF, 18'h3FFFF, 1'b0);

    // random mix (R10: single pulse per transfer throughout)
    for (int n = 0; n < 60; n++) begin
      logic [2:0] m = 3'($urandom_range(0, 7));
      logic a0 = 1'($urandom);
      logic [W-1:0] d1 = W'($urandom), d2 = W'($urandom);
      bit cs_on = ($urandom_range(0, 9) != 0);
      set_mode(m);
      if ($urandom_range(0, 1) == 0) do_write(a0, d1, cs_on);
      else                           do_read(a0, d1, d2, cs_on);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule